// File: doc/BRIEF.md
# PWM Output Conditioning and Steering Stage

This block sits between a three-phase PWM timing unit and the gate-drive pins. It takes the raw high-side and low-side signal of each phase and applies the last transformations before the pins, always in the same order. First comes a switched-reluctance forcing mode. Then come a per-phase swap of the high and low signals for brushless commutation, and a per-pin enable. After that the signals are mixed with a high-frequency chopping carrier for pulse-transformer gate drives. A global polarity select comes last, and a trip input overrides everything.

The transformed logical levels are registered once. Polarity and trip are applied after that register, so a trip reaches the pins within the same cycle. The chopping carrier is a 50% square wave. Its half-period is (divider + 1) times a fixed prescale of the clock. The carrier gates only outputs that are already active, so chopping never turns an output on.

Top module: `pwm_out_stage`

## Requirements
- R1: While rst_ni is low, every output sits at its inactive level: 0 when pol_hi_i is 1, and 1 when pol_hi_i is 0.
- R2: With srm_n_i=1, no swap, all enables set, chopping off, pol_hi_i=1 and trip_i=0, each output equals its raw input one clock later.
- R3: When srm_n_i is 0, all three low-side signals are forced active regardless of pwm_lo_i, and the high-side signals still follow pwm_hi_i.
- R4: When swap_i[p] is 1, phase p's high output carries that phase's low signal and its low output carries the high signal. The other phases are unaffected.
- R5: In out_en_i, bits [2:0] enable drv_hi_o[2:0] and bits [5:3] enable drv_lo_o[2:0]. A cleared bit holds its pin at the inactive level.
- R6: The chopping carrier alternates between high and low, each for (chop_div_i+1)*CHOP_PRESC clocks. While chop_hi_en_i=1, the active high-side outputs toggle at that rate.
- R7: chop_lo_en_i chops only the low-side outputs and chop_hi_en_i only the high-side outputs.
- R8: Chopping is ANDed with the active level only, so an inactive output stays inactive while chopping is enabled.
- R9: With pol_hi_i=0, all six outputs are the inverse of their active-high values.
- R10: While trip_i is 1, all outputs are at the inactive level in the same cycle, whatever the other controls are. When trip_i is released, the outputs follow the stage again.
- R11: The operations apply in this order: reluctance forcing, then swap, then enable. A forced low-side signal that is swapped appears on the high pin, and it is gated by that pin's enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pwm_hi_i | input | 3 | Raw high-side signals, phase A at bit 0 |
| pwm_lo_i | input | 3 | Raw low-side signals, phase A at bit 0 |
| srm_n_i | input | 1 | Low selects switched-reluctance forcing |
| swap_i | input | 3 | Per-phase high/low swap |
| out_en_i | input | 6 | Per-pin enables: [2:0] high side, [5:3] low side |
| chop_div_i | input | 8 | Chopping carrier divider |
| chop_hi_en_i | input | 1 | Chop the high-side group |
| chop_lo_en_i | input | 1 | Chop the low-side group |
| pol_hi_i | input | 1 | 1 selects active-high outputs |
| trip_i | input | 1 | Forces all outputs inactive |
| drv_hi_o | output | 3 | High-side pin drives |
| drv_lo_o | output | 3 | Low-side pin drives |

## Verification
The bench builds the block with CHOP_PRESC=2 and keeps the default 8-bit divider and three phases. This makes carrier half-periods of 2 and 8 clocks short enough to measure as run lengths on the pins in a few hundred cycles. Measuring run lengths rather than phase makes the check independent of where the carrier sits after reset. The short prescale also leaves room to observe that an idle output stays flat in both polarities while chopping is enabled.

// File: rtl/pwm_out_pkg.sv
package pwm_out_pkg;
  typedef struct packed {
    logic hi;
    logic lo;
  } leg_pair_t;
endpackage

// File: rtl/pwm_chop_gen.sv
module pwm_chop_gen #(
  parameter int DIV_W = 8,
  parameter int PRESC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_i,
  output logic             carrier_o
);
  localparam int PRE_W = (PRESC > 1) ? $clog2(PRESC) : 1;

  logic [PRE_W-1:0] pre_q;
  logic [DIV_W-1:0] half_q;
  logic             car_q;
  logic             tick;

  assign tick = (pre_q == PRE_W'(PRESC - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q  <= '0;
      half_q <= '0;
      car_q  <= 1'b1;
    end else begin
      pre_q <= tick ? '0 : pre_q + 1'b1;
      if (tick) begin
        // >= keeps the count bounded when the divider shrinks mid-period
        if (half_q >= div_i) begin
          half_q <= '0;
          car_q  <= ~car_q;
        end else begin
          half_q <= half_q + 1'b1;
        end
      end
    end
  end

  assign carrier_o = car_q;
endmodule

// File: rtl/pwm_phase_path.sv
module pwm_phase_path
  import pwm_out_pkg::*;
(
  input  leg_pair_t raw_i,
  input  logic      srm_n_i,
  input  logic      swap_i,
  input  logic      en_hi_i,
  input  logic      en_lo_i,
  input  logic      carrier_i,
  input  logic      chop_hi_en_i,
  input  logic      chop_lo_en_i,
  output leg_pair_t act_o
);
  leg_pair_t forced, steered, gated;

  always_comb begin
    forced.hi  = raw_i.hi;
    forced.lo  = raw_i.lo | ~srm_n_i;
    steered.hi = swap_i ? forced.lo : forced.hi;
    steered.lo = swap_i ? forced.hi : forced.lo;
    gated.hi   = steered.hi & en_hi_i;
    gated.lo   = steered.lo & en_lo_i;
    act_o.hi   = gated.hi & (carrier_i | ~chop_hi_en_i);
    act_o.lo   = gated.lo & (carrier_i | ~chop_lo_en_i);
  end
endmodule

// File: rtl/pwm_out_stage.sv
module pwm_out_stage
  import pwm_out_pkg::*;
#(
  parameter int NPH        = 3,
  parameter int DIV_W      = 8,
  parameter int CHOP_PRESC = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NPH-1:0]   pwm_hi_i,
  input  logic [NPH-1:0]   pwm_lo_i,
  input  logic             srm_n_i,
  input  logic [NPH-1:0]   swap_i,
  input  logic [2*NPH-1:0] out_en_i,
  input  logic [DIV_W-1:0] chop_div_i,
  input  logic             chop_hi_en_i,
  input  logic             chop_lo_en_i,
  input  logic             pol_hi_i,
  input  logic             trip_i,
  output logic [NPH-1:0]   drv_hi_o,
  output logic [NPH-1:0]   drv_lo_o
);
  logic           carrier;
  logic [NPH-1:0] act_hi_d, act_lo_d, act_hi_q, act_lo_q;

  pwm_chop_gen #(.DIV_W(DIV_W), .PRESC(CHOP_PRESC)) u_chop (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .div_i     (chop_div_i),
    .carrier_o (carrier)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    leg_pair_t raw, act;
    assign raw.hi = pwm_hi_i[p];
    assign raw.lo = pwm_lo_i[p];
    pwm_phase_path u_path (
      .raw_i        (raw),
      .srm_n_i      (srm_n_i),
      .swap_i       (swap_i[p]),
      .en_hi_i      (out_en_i[p]),
      .en_lo_i      (out_en_i[NPH+p]),
      .carrier_i    (carrier),
      .chop_hi_en_i (chop_hi_en_i),
      .chop_lo_en_i (chop_lo_en_i),
      .act_o        (act)
    );
    assign act_hi_d[p] = act.hi;
    assign act_lo_d[p] = act.lo;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_hi_q <= '0;
      act_lo_q <= '0;
    end else begin
      act_hi_q <= act_hi_d;
      act_lo_q <= act_lo_d;
    end
  end

  // trip acts after the register so it reaches the pins without delay
  assign drv_hi_o = (act_hi_q & {NPH{~trip_i}}) ^ {NPH{~pol_hi_i}};
  assign drv_lo_o = (act_lo_q & {NPH{~trip_i}}) ^ {NPH{~pol_hi_i}};
endmodule

// File: rtl/pwm_out_stage_chk.sv
module pwm_out_stage_chk #(
  parameter int NPH = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             srm_n_i,
  input logic [NPH-1:0]   swap_i,
  input logic [2*NPH-1:0] out_en_i,
  input logic             chop_lo_en_i,
  input logic             pol_hi_i,
  input logic             trip_i,
  input logic [NPH-1:0]   drv_hi_o,
  input logic [NPH-1:0]   drv_lo_o
);
  logic [2*NPH-1:0] act_pins;
  assign act_pins = {drv_lo_o, drv_hi_o} ^ {2*NPH{~pol_hi_i}};

  // R1
  reset_inactive_chk: assert property (@(posedge clk_i)
    !rst_ni |-> act_pins == '0);

  // R10
  trip_override_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_i |-> act_pins == '0);

  // R5
  disabled_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (act_pins & ~$past(out_en_i)) == '0);

  // R3
  srm_force_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!srm_n_i && swap_i == '0 && &out_en_i[2*NPH-1:NPH] && !chop_lo_en_i)
      |=> (trip_i || act_pins[2*NPH-1:NPH] == '1));
endmodule

bind pwm_out_stage pwm_out_stage_chk #(.NPH(NPH)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .srm_n_i      (srm_n_i),
  .swap_i       (swap_i),
  .out_en_i     (out_en_i),
  .chop_lo_en_i (chop_lo_en_i),
  .pol_hi_i     (pol_hi_i),
  .trip_i       (trip_i),
  .drv_hi_o     (drv_hi_o),
  .drv_lo_o     (drv_lo_o)
);

// File: tb/sim_pwm_out_stage.sv
`timescale 1ns/1ps
module sim_pwm_out_stage;
  localparam int PRESC = 2;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [2:0] pwm_hi_i = '0, pwm_lo_i = '0, swap_i = '0;
  logic       srm_n_i = 1'b1;
  logic [5:0] out_en_i = '1;
  logic [7:0] chop_div_i = '0;
  logic       chop_hi_en_i = 1'b0, chop_lo_en_i = 1'b0;
  logic       pol_hi_i = 1'b1, trip_i = 1'b0;
  logic [2:0] drv_hi_o, drv_lo_o;

  int n_run = 0, n_fail = 0;

  always #10 clk_i = ~clk_i;

  pwm_out_stage #(.CHOP_PRESC(PRESC)) u0 (.*);

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [5:0] pins();
    return {drv_lo_o, drv_hi_o};
  endfunction

  task automatic defaults();
    pwm_hi_i = '0; pwm_lo_i = '0; swap_i = '0; srm_n_i = 1'b1;
    out_en_i = '1; chop_hi_en_i = 1'b0; chop_lo_en_i = 1'b0;
    pol_hi_i = 1'b1; trip_i = 1'b0;
  endtask

  // runs of equal value on one pin; returns lengths of runs 2 and 3
  task automatic runs(int bitsel, int win, output int r2, output int r3, output int ntr);
    logic prev;
    int len, idx;
    prev = pins()[bitsel]; len = 0; idx = 0; r2 = -1; r3 = -1; ntr = 0;
    for (int i = 0; i < win; i++) begin
      step();
      len++;
      if (pins()[bitsel] !== prev) begin
        idx++; ntr++;
        if (idx == 2) r2 = len;
        if (idx == 3) r3 = len;
        len = 0;
        prev = pins()[bitsel];
      end
    end
  endtask

  task automatic t_reset();
    #1 chk("R1 reset active-high", pins(), 6'b000000);
    pol_hi_i = 1'b0;
    #1 chk("R1 reset active-low", pins(), 6'b111111);
    pol_hi_i = 1'b1;
    @(negedge clk_i); rst_ni = 1'b1;
    step();
  endtask

  task automatic t_pass();
    logic [5:0] pat [4] = '{6'b101010, 6'b010101, 6'b111000, 6'b000111};
    defaults();
    foreach (pat[i]) begin
      {pwm_lo_i, pwm_hi_i} = pat[i];
      step();
      chk("R2 pass-through", pins(), pat[i]);
    end
  endtask

  task automatic t_srm();
    defaults();
    srm_n_i = 1'b0; pwm_hi_i = 3'b101; pwm_lo_i = 3'b000;
    step();
    chk("R3 reluctance forcing", pins(), 6'b111_101);
    pwm_hi_i = 3'b010;
    step();
    chk("R3 high follows", pins(), 6'b111_010);
  endtask

  task automatic t_swap();
    defaults();
    swap_i = 3'b010; pwm_hi_i = 3'b011; pwm_lo_i = 3'b100;
    step();
    chk("R4 swap phase B", pins(), 6'b110_001);
    swap_i = 3'b111;
    step();
    chk("R4 swap all", pins(), 6'b011_100);
  endtask

  task automatic t_enable();
    defaults();
    pwm_hi_i = '1; pwm_lo_i = '1; out_en_i = 6'b011_101;
    step();
    chk("R5 enables", pins(), 6'b011_101);
    pol_hi_i = 1'b0;
    step();
    chk("R5 enables active-low", pins(), 6'b100_010);
  endtask

  task automatic t_chop();
    int r2, r3, nt;
    defaults();
    pwm_hi_i = '1; pwm_lo_i = '1; chop_hi_en_i = 1'b1;
    chop_div_i = 8'd3;
    runs(0, 12, r2, r3, nt);
    runs(0, 200, r2, r3, nt);
    chk("R6 half period div=3", 6'(r2), 6'(4 * PRESC));
    chk("R6 half period div=3 next", 6'(r3), 6'(4 * PRESC));
    runs(3, 60, r2, r3, nt);
    chk("R7 low side unchopped", 6'(nt), 6'd0);
    chop_div_i = 8'd0;
    runs(0, 40, r2, r3, nt);
    runs(0, 40, r2, r3, nt);
    chk("R6 half period div=0", 6'(r2), 6'(PRESC));
    chop_hi_en_i = 1'b0; chop_lo_en_i = 1'b1;
    step();
    runs(0, 40, r2, r3, nt);
    chk("R7 high side unchopped", 6'(nt), 6'd0);
    runs(4, 40, r2, r3, nt);
    chk("R7 low side chopped", 6'(r2), 6'(PRESC));
    pwm_hi_i = '0; pwm_lo_i = '0; chop_hi_en_i = 1'b1;
    step();
    runs(0, 40, r2, r3, nt);
    chk("R8 idle stays idle", {nt[4:0], pins()[0]}, 6'd0);
    pol_hi_i = 1'b0;
    step();
    runs(3, 40, r2, r3, nt);
    chk("R8 idle active-low", {nt[4:0], pins()[3]}, 6'd1);
    chop_div_i = 8'd0;
  endtask

  task automatic t_pol();
    defaults();
    pol_hi_i = 1'b0; pwm_hi_i = 3'b110; pwm_lo_i = 3'b001;
    step();
    chk("R9 polarity invert", pins(), 6'b110_001);
  endtask

  task automatic t_trip();
    defaults();
    pwm_hi_i = '1; pwm_lo_i = 3'b101; srm_n_i = 1'b0;
    step();
    trip_i = 1'b1;
    #1 chk("R10 trip same cycle", pins(), 6'b000000);
    pol_hi_i = 1'b0;
    #1 chk("R10 trip active-low", pins(), 6'b111111);
    step();
    chk("R10 trip held", pins(), 6'b111111);
    trip_i = 1'b0; pol_hi_i = 1'b1;
    #1 chk("R10 trip released", pins(), 6'b111111);
  endtask

  task automatic t_order();
    defaults();
    srm_n_i = 1'b0; swap_i = 3'b001;
    step();
    chk("R11 forced low swapped to high", pins(), 6'b110_001);
    out_en_i = 6'b111_110;
    step();
    chk("R11 enable after swap", pins(), 6'b110_000);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    t_reset();
    t_pass();
    t_srm();
    t_swap();
    t_enable();
    t_chop();
    t_pol();
    t_trip();
    t_order();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule